// File: doc/BRIEF.md
# Framed Word Serializer

This transmitter takes a 10-bit parallel word once per reference period and sends it out one bit at a time as a 12-bit frame, least significant data bit first. A forced-high start bit leads each frame and a forced-low stop bit ends it. That guarantees an edge at every frame boundary, which a receiver can lock onto. The fast bit clock is the only clock. An internal counter that runs from 0 to 11 divides it by twelve. From that count the block makes a modeled reference clock: high for counts 0 to 5 and low for counts 6 to 11. It also makes a word strobe that is high when the count is 11.

A select input picks which reference edge captures the parallel word: the rising edge at the 11-to-0 wrap, or the falling edge at the 5-to-6 step. A mode input, sampled at the word strobe, sends either the framed data word or a fixed synchronization symbol of six ones then six zeros. A drive-enable input stands in for a tri-state driver. It forces the serial bit low and clears the valid flag. It does not disturb the internal frame timing.

Top module: `ser_frame_tx`

## Requirements
- R1: A data frame is sent as: start bit 1, then data bits 0 through 9 in that order, then stop bit 0. The frame holds the word that was last captured before the word strobe that loaded it.
- R2: The reference clock output is high while the internal count is 0 to 5 and low while it is 6 to 11. The word strobe is high only at count 11. The count advances once per bit clock, starting at 0 after reset.
- R3: With edge select high, the captured word is the data input present in the bit-clock cycle where the word strobe is high (the rising reference edge).
- R4: With edge select low, the captured word is the data input present in the last cycle with the reference clock high, which is count 5 (the falling reference edge).
- R5: When the mode input is high at the word strobe, the frame that follows is six ones followed by six zeros. The data input has no effect on it.
- R6: Between two consecutive enabled frames, the stop bit 0 is followed directly by the start bit 1.
- R7: The serial output and the valid flag are registered. The valid flag equals the drive enable one clock earlier. While that delayed enable is low, the serial output is 0. The frame timing and content carry on unchanged.
- R8: During reset and right after it: serial output 0, valid 0, reference clock 1, word strobe 0.
- R9: The mode input and the captured word are taken only at the word strobe. Changes at other times never alter a frame already in progress.
- R10: Output timing: frame bit k appears on the serial output in the cycle where the count is k+1 modulo 12. The start bit therefore appears at count 1 and the stop bit at count 0 of the next period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit-rate clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| data_i | input | 10 | Parallel data word |
| edge_sel_i | input | 1 | 1: capture on rising reference edge, 0: on falling |
| sync_i | input | 1 | 1: send sync symbol instead of data |
| drv_en_i | input | 1 | Output drive enable |
| ser_o | output | 1 | Serial data bit |
| ser_vld_o | output | 1 | Output driven flag |
| ref_clk_o | output | 1 | Modeled reference clock (bit clock / 12) |
| word_stb_o | output | 1 | One-in-twelve word strobe |

## Verification
The data input changes to a new random value every bit clock. If the design captured one cycle early or late, or on the wrong reference edge, the wrong word would go out on the line. The mode input also toggles in the middle of frames. A design that sampled it outside the strobe would send a frame that mixes sync and data bits. All-zero and all-one words check that the start and stop bits are still forced at the frame boundary. The drive enable toggles at random. A design that let it reset the frame state would lose the frame timing, and a design that left the serial output driven while the enable was low would show data during the disabled cycles.

// File: rtl/ser_pkg.sv
package ser_pkg;
  typedef enum logic [0:0] {
    SYM_DATA = 1'b0,
    SYM_SYNC = 1'b1
  } sym_sel_e;
endpackage

// File: rtl/ser_timing.sv
module ser_timing #(
  parameter int FRAME_W = 12
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic stb_o,
  output logic mid_o,
  output logic ref_clk_o
);
  localparam int CNT_W = $clog2(FRAME_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_W - 1);
  localparam logic [CNT_W-1:0] MID  = CNT_W'(FRAME_W / 2 - 1);
  localparam logic [CNT_W-1:0] HALF = CNT_W'(FRAME_W / 2);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (cnt_q == LAST)  cnt_q <= '0;
    else                     cnt_q <= cnt_q + 1'b1;
  end

  assign stb_o     = (cnt_q == LAST);
  assign mid_o     = (cnt_q == MID);
  assign ref_clk_o = (cnt_q < HALF);

  // R2
  stb_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stb_o |=> !stb_o);
  // R2
  ref_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ref_clk_o) |-> $past(stb_o));
endmodule

// File: rtl/ser_capture.sv
module ser_capture #(
  parameter int DATA_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] data_i,
  input  logic              edge_sel_i,
  input  logic              stb_i,
  input  logic              mid_i,
  output logic [DATA_W-1:0] hold_o
);
  logic              cap;
  logic [DATA_W-1:0] hold_q;

  // rising reference edge coincides with the strobe, falling with mid count
  assign cap = edge_sel_i ? stb_i : mid_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  hold_q <= '0;
    else if (cap) hold_q <= data_i;
  end

  assign hold_o = hold_q;

  // R3 R4
  hold_chg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(hold_q) |-> ($past(edge_sel_i) ? $past(stb_i) : $past(mid_i)));
endmodule

// File: rtl/ser_framer.sv
module ser_framer
  import ser_pkg::*;
#(
  parameter int DATA_W  = 10,
  parameter int FRAME_W = DATA_W + 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              stb_i,
  input  logic              sync_i,
  input  logic [DATA_W-1:0] hold_i,
  output logic              bit_o
);
  logic [FRAME_W-1:0] data_frame;
  logic [FRAME_W-1:0] sync_frame;
  logic [FRAME_W-1:0] sr_q;
  sym_sel_e           sel;

  // LSB leaves first: start, d0..dN, stop
  assign data_frame[0]         = 1'b1;
  assign data_frame[FRAME_W-1] = 1'b0;
  for (genvar gi = 0; gi < DATA_W; gi++) begin : g_dbit
    assign data_frame[gi+1] = hold_i[gi];
  end

  for (genvar gi = 0; gi < FRAME_W; gi++) begin : g_sbit
    assign sync_frame[gi] = (gi < FRAME_W / 2) ? 1'b1 : 1'b0;
  end

  assign sel = sync_i ? SYM_SYNC : SYM_DATA;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    sr_q <= '0;
    else if (stb_i) sr_q <= (sel == SYM_SYNC) ? sync_frame : data_frame;
    else            sr_q <= {1'b0, sr_q[FRAME_W-1:1]};
  end

  assign bit_o = sr_q[0];

  // R5
  sync_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stb_i && sync_i) |=> (sr_q[0] && !sr_q[FRAME_W-1] &&
                           $countones(sr_q) == FRAME_W / 2));
  // R1
  data_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stb_i && !sync_i) |=> (sr_q[0] && !sr_q[FRAME_W-1] &&
                            sr_q[DATA_W:1] == $past(hold_i)));
endmodule

// File: rtl/ser_outreg.sv
module ser_outreg (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bit_i,
  input  logic en_i,
  output logic ser_o,
  output logic vld_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ser_o <= 1'b0;
      vld_o <= 1'b0;
    end else begin
      ser_o <= en_i & bit_i;
      vld_o <= en_i;
    end
  end

  // R7
  en_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!ser_o && !vld_o));
endmodule

// File: rtl/ser_frame_tx.sv
module ser_frame_tx #(
  parameter int DATA_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] data_i,
  input  logic              edge_sel_i,
  input  logic              sync_i,
  input  logic              drv_en_i,
  output logic              ser_o,
  output logic              ser_vld_o,
  output logic              ref_clk_o,
  output logic              word_stb_o
);
  localparam int FRAME_W = DATA_W + 2;

  logic              stb;
  logic              mid;
  logic [DATA_W-1:0] hold;
  logic              sr_bit;

  ser_timing #(.FRAME_W(FRAME_W)) u_timing (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .stb_o     (stb),
    .mid_o     (mid),
    .ref_clk_o (ref_clk_o)
  );

  ser_capture #(.DATA_W(DATA_W)) u_capture (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .data_i     (data_i),
    .edge_sel_i (edge_sel_i),
    .stb_i      (stb),
    .mid_i      (mid),
    .hold_o     (hold)
  );

  ser_framer #(.DATA_W(DATA_W), .FRAME_W(FRAME_W)) u_framer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .stb_i  (stb),
    .sync_i (sync_i),
    .hold_i (hold),
    .bit_o  (sr_bit)
  );

  ser_outreg u_out (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .bit_i  (sr_bit),
    .en_i   (drv_en_i),
    .ser_o  (ser_o),
    .vld_o  (ser_vld_o)
  );

  assign word_stb_o = stb;

  // R6
  frame_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(word_stb_o, 2) && ser_vld_o && $past(ser_vld_o)) |->
      (ser_o && !$past(ser_o)));
endmodule

// File: tb/ser_frame_tx_tb.sv
module ser_frame_tx_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [9:0] data_i = '0;
  logic       edge_sel_i = 1'b1;
  logic       sync_i = 1'b0;
  logic       drv_en_i = 1'b0;
  logic       ser_o, ser_vld_o, ref_clk_o, word_stb_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  // reference model state
  int         m_cnt = 0;
  logic [9:0] m_hold = '0;
  logic [11:0] m_sr = '0;
  logic       m_ser = 1'b0;
  logic       m_vld = 1'b0;
  logic       prev_ser = 1'b0;
  logic       prev_vld = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  ser_frame_tx u_dut (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .data_i     (data_i),
    .edge_sel_i (edge_sel_i),
    .sync_i     (sync_i),
    .drv_en_i   (drv_en_i),
    .ser_o      (ser_o),
    .ser_vld_o  (ser_vld_o),
    .ref_clk_o  (ref_clk_o),
    .word_stb_o (word_stb_o)
  );

  task automatic chk(input string tag, input logic [11:0] got, input logic [11:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %0h expected %0h at %0t", tag, got, exp, $time);
    end
  endtask

  // frame image from the requirements: start 1, d0..d9, stop 0 (LSB first)
  function automatic logic [11:0] data_frame(input logic [9:0] d);
    return {1'b0, d, 1'b1};
  endfunction

  function automatic logic [11:0] sync_frame();
    return 12'h03F;
  endfunction

  // sync_mode / en_mode: 0 off, 1 on, 2 random; data_mode: 0 random, 1 zeros, 2 ones
  task automatic step(input string tag, input int sync_mode, input int en_mode,
                      input int data_mode);
    logic stb, cap;
    case (data_mode)
      1: data_i = '0;
      2: data_i = '1;
      default: data_i = 10'($urandom);
    endcase
    sync_i   = (sync_mode == 2) ? 1'($urandom) : (sync_mode == 1);
    drv_en_i = (en_mode == 2) ? ($urandom_range(0, 3) != 0) : (en_mode == 1);
    // predict the next clock edge
    stb = (m_cnt == 11);
    cap = edge_sel_i ? stb : (m_cnt == 5);
    m_ser = drv_en_i & m_sr[0];
    m_vld = drv_en_i;
    if (stb) m_sr = sync_i ? sync_frame() : data_frame(m_hold);
    else     m_sr = {1'b0, m_sr[11:1]};
    if (cap) m_hold = data_i;
    m_cnt = stb ? 0 : m_cnt + 1;
    @(negedge clk_i);
    chk(tag, 12'(ser_o), 12'(m_ser));
    chk("R7", 12'(ser_vld_o), 12'(m_vld));
    chk("R2", 12'(ref_clk_o), 12'(m_cnt < 6));
    chk("R2", 12'(word_stb_o), 12'(m_cnt == 11));
    if (m_cnt == 1 && ser_vld_o && prev_vld)
      chk("R6", {10'd0, prev_ser, ser_o}, 12'b01);
    prev_ser = ser_o;
    prev_vld = ser_vld_o;
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk_i);
    // R8 during reset
    chk("R8", {8'd0, ser_o, ser_vld_o, ref_clk_o, word_stb_o}, 12'b0010);
    rst_ni = 1'b1;
    // R8 right after release
    chk("R8", {8'd0, ser_o, ser_vld_o, ref_clk_o, word_stb_o}, 12'b0010);
    // R1 R3 R10: rising capture, data changes every cycle
    edge_sel_i = 1'b1;
    for (int i = 0; i < 240; i++) step("R1 R3 R10", 0, 1, 0);
    // R4: falling capture
    edge_sel_i = 1'b0;
    for (int i = 0; i < 240; i++) step("R4 R10", 0, 1, 0);
    // R5: sync symbol, data ignored
    for (int i = 0; i < 120; i++) step("R5", 1, 1, 0);
    // R9: mode toggling mid-frame, both edges
    for (int i = 0; i < 240; i++) begin
      if (i == 120) edge_sel_i = 1'b1;
      step("R9", 2, 1, 0);
    end
    // R7: drive enable toggling
    for (int i = 0; i < 240; i++) step("R7", 2, 2, 0);
    // R6: all-zero and all-one words
    for (int i = 0; i < 120; i++) step("R6 R1", 0, 1, 1);
    edge_sel_i = 1'b0;
    for (int i = 0; i < 120; i++) step("R6 R1", 0, 1, 2);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule